// File: doc/BRIEF.md
# Tile Video Controller Host Command Port

This block is the host-facing write side of a tile video controller. The host sees two 16-bit ports: a control port and a data port. A control word either loads one of the controller's byte-wide configuration registers, or forms one half of a two-word command. That command sets the current memory address and selects the memory that later data writes go to. Each data-port write is turned into a write strobe toward video RAM or colour RAM at the current address. The address then moves on by a step that software programs in one of the registers.

The register file, the address pointer, the selected target and the flag that marks a half-received command all live here. The rest of the controller reads any register through a select/value pair. It takes memory writes from the registered strobe, address and data outputs. A 32-bit host store is seen as two 16-bit data writes, high half first, and each of them advances the pointer.

Top module: `vidctl_host_port`

## Requirements
- R1: After reset all 24 registers read 0, no write strobe is raised, and data writes issue no strobe until an address command selects a memory (the reset target is code 00 and the step is 0).
- R2: A control word whose bits 15:13 are 100, received with no command pending, loads bits 7:0 into the register selected by bits 12:8. The new value is readable on the register read port from the cycle after the write.
- R3: A register write to an index from 24 to 31 changes no register, and the read port returns 0 for those indices.
- R4: Any other control word received with no command pending sets the target code from bits 15:14 and address bits 13:0 from bits 13:0, and marks a command pending. The next control word, whatever its top bits, sets address bits 15:14 from its bits 1:0, writes no register, and clears the pending mark.
- R5: With target code 01, a data write raises `vram_we` for one cycle in the following cycle, with `vram_waddr` equal to address bits 15:1 and `mem_wdata` equal to the written word.
- R6: With target code 11, a data write raises `cram_we` in the following cycle, with `cram_waddr` equal to address bits 6:1. Higher address bits have no effect on the index.
- R7: With target code 00 or 10, data writes raise neither strobe.
- R8: Every data write advances the 16-bit address by the value of register 15, modulo 65536.
- R9: A control-port read, with no control write in the same cycle, clears a pending command, so the next register-form word is taken as a register write.
- R10: Data writes on consecutive cycles each produce their own strobe on consecutive cycles, at successive addresses.
- R11: If a control write and a data write arrive in the same cycle, the control write is applied and the data write is dropped: no strobe and no address advance.
- R12: `vram_we` and `cram_we` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control-port write strobe |
| ctrl_rd | input | 1 | Control-port read strobe (clears a pending command) |
| data_wr | input | 1 | Data-port write strobe |
| host_wdata | input | 16 | Word written to the control or data port |
| reg_rd_sel | input | 5 | Register index for the read port |
| reg_rd_val | output | 8 | Value of the selected register (0 for indices 24..31) |
| vram_we | output | 1 | Video RAM word write strobe |
| vram_waddr | output | 15 | Video RAM word address |
| cram_we | output | 1 | Colour RAM write strobe |
| cram_waddr | output | 6 | Colour RAM entry index |
| mem_wdata | output | 16 | Write data for either memory |

## Verification
Register contents appear on the read port in the cycle after the edge that took the control write, because the read mux follows the register flops directly. Memory strobes, addresses and data are registered, so they are due exactly one cycle after the edge that takes the data write, and they last one cycle. The bench drives every input on a falling edge and holds it across one rising edge. It samples strobe results at the next falling edge and register values a few nanoseconds after a falling edge, with all inputs idle. Back-to-back data writes are checked on each falling edge of the burst, so each strobe is seen in its own cycle.

// File: rtl/vidctl_pkg.sv
// Package: shared encodings for the host command port.
// Assumes 16-bit host words; the register-write tag and target codes are fixed
// by the command format and must not change.
package vidctl_pkg;
    localparam int unsigned HOST_W      = 16;
    localparam logic [2:0]  REGWR_TAG   = 3'b100;
    localparam int unsigned REGIDX_LSB  = 8;

    // Memory target selected by bits 15:14 of the first command word.
    typedef enum logic [1:0] {
        TGT_NONE0 = 2'b00,
        TGT_VRAM  = 2'b01,
        TGT_NONE2 = 2'b10,
        TGT_CRAM  = 2'b11
    } tgt_e;
endpackage

// File: rtl/vidctl_ctrl_decode.sv
// Module: splits a control word into its register-write fields.
// Assumes the register index sits directly above the value byte and that the
// tag occupies the top three bits; the pending-command override is applied by
// the address unit, not here.
module vidctl_ctrl_decode
    import vidctl_pkg::*;
#(
    parameter int unsigned IDX_W = 5,
    parameter int unsigned REG_W = 8
) (
    input  logic [HOST_W-1:0] ctrl_word,
    output logic              reg_form,
    output logic [IDX_W-1:0]  reg_idx,
    output logic [REG_W-1:0]  reg_val
);
    localparam int unsigned IDX_MSB = REGIDX_LSB + IDX_W - 1;

    // Field extraction for a register-form word.
    always_comb begin
        reg_form = (ctrl_word[HOST_W-1 -: 3] == REGWR_TAG);
        reg_idx  = ctrl_word[IDX_MSB:REGIDX_LSB];
        reg_val  = ctrl_word[REG_W-1:0];
    end
endmodule

// File: rtl/vidctl_regfile.sv
// Module: byte-wide configuration register file with one write port and one
// read port. Assumes writes to indices at or above NUM_REGS are dropped and
// that such indices read as zero. Exposes the address step register directly.
module vidctl_regfile #(
    parameter int unsigned NUM_REGS = 24,
    parameter int unsigned IDX_W    = 5,
    parameter int unsigned REG_W    = 8,
    parameter int unsigned STEP_IDX = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [REG_W-1:0] wr_val,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [REG_W-1:0] rd_val,
    output logic [REG_W-1:0] step
);
    logic [NUM_REGS-1:0][REG_W-1:0] regs;
    logic [NUM_REGS-1:0]            hit;

    // One write-enable decode per register.
    genvar g;
    generate
        for (g = 0; g < NUM_REGS; g++) begin : g_hit
            assign hit[g] = wr_en && (wr_idx == IDX_W'(g));
        end
    endgenerate

    // Register storage: clear on reset, load on a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            regs <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (hit[i]) regs[i] <= wr_val;
            end
        end
    end

    // Read mux; unmatched indices return zero.
    always_comb begin
        rd_val = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (rd_idx == IDX_W'(i)) rd_val = regs[i];
        end
    end

    assign step = regs[STEP_IDX];

    assert_step_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx == IDX_W'(STEP_IDX)) |=> (step == $past(wr_val)));

    assert_high_index_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_idx >= IDX_W'(NUM_REGS)) |=> $stable(regs));
endmodule

// File: rtl/vidctl_addr_unit.sv
// Module: address pointer, memory target and pending-command flag.
// Assumes the host never needs a control write and a data advance to apply in
// the same cycle: the control write wins and the advance is dropped.
module vidctl_addr_unit
    import vidctl_pkg::*;
#(
    parameter int unsigned ADDR_W = 16,
    parameter int unsigned LOW_W  = 14,
    parameter int unsigned STEP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic              ctrl_rd,
    input  logic [HOST_W-1:0] ctrl_word,
    input  logic              reg_form,
    input  logic              data_adv,
    input  logic [STEP_W-1:0] step,
    output logic              reg_wr_en,
    output logic [ADDR_W-1:0] ptr,
    output tgt_e              tgt,
    output logic              pending
);
    localparam int unsigned HI_W = ADDR_W - LOW_W;

    // A register write is only taken when no command half is outstanding.
    assign reg_wr_en = ctrl_wr && !pending && reg_form;

    // Command sequencing and pointer advance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr     <= '0;
            tgt     <= TGT_NONE0;
            pending <= 1'b0;
        end else if (ctrl_wr) begin
            if (pending) begin
                ptr[ADDR_W-1:LOW_W] <= ctrl_word[HI_W-1:0];
                pending             <= 1'b0;
            end else if (!reg_form) begin
                tgt          <= tgt_e'(ctrl_word[HOST_W-1 -: 2]);
                ptr[LOW_W-1:0] <= ctrl_word[LOW_W-1:0];
                pending      <= 1'b1;
            end
        end else begin
            if (ctrl_rd)  pending <= 1'b0;
            if (data_adv) ptr     <= ptr + ADDR_W'(step);
        end
    end

    assert_second_word_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && pending) |=> (!pending && ptr[ADDR_W-1:LOW_W] == $past(ctrl_word[HI_W-1:0])));

    assert_advance_by_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_adv && !ctrl_wr) |=> (ptr == $past(ptr) + ADDR_W'($past(step))));

    assert_read_clears_pending_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rd && !ctrl_wr) |=> !pending);
endmodule

// File: rtl/vidctl_host_port.sv
// Module: top of the host command port. Decodes control words, holds the
// register file and address state, and issues registered one-cycle write
// strobes toward video RAM and colour RAM.
// Assumes the memories accept one write per cycle with no back-pressure.
module vidctl_host_port
    import vidctl_pkg::*;
#(
    parameter int unsigned NUM_REGS   = 24,
    parameter int unsigned IDX_W      = 5,
    parameter int unsigned REG_W      = 8,
    parameter int unsigned STEP_IDX   = 15,
    parameter int unsigned ADDR_W     = 16,
    parameter int unsigned LOW_W      = 14,
    parameter int unsigned CRAM_IDX_W = 6
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic                ctrl_rd,
    input  logic                data_wr,
    input  logic [15:0]         host_wdata,
    input  logic [IDX_W-1:0]    reg_rd_sel,
    output logic [REG_W-1:0]    reg_rd_val,
    output logic                vram_we,
    output logic [ADDR_W-2:0]   vram_waddr,
    output logic                cram_we,
    output logic [CRAM_IDX_W-1:0] cram_waddr,
    output logic [15:0]         mem_wdata
);
    logic              reg_form;
    logic [IDX_W-1:0]  reg_idx;
    logic [REG_W-1:0]  reg_val;
    logic              reg_wr_en;
    logic [REG_W-1:0]  step;
    logic [ADDR_W-1:0] ptr;
    tgt_e              tgt;
    logic              pending;
    logic              data_go;
    logic              unused_ptr_lsb;

    assign data_go        = data_wr && !ctrl_wr;
    assign unused_ptr_lsb = ptr[0];

    vidctl_ctrl_decode #(.IDX_W(IDX_W), .REG_W(REG_W)) u_decode (
        .ctrl_word (host_wdata),
        .reg_form  (reg_form),
        .reg_idx   (reg_idx),
        .reg_val   (reg_val)
    );

    vidctl_regfile #(
        .NUM_REGS(NUM_REGS), .IDX_W(IDX_W), .REG_W(REG_W), .STEP_IDX(STEP_IDX)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr_en),
        .wr_idx (reg_idx),
        .wr_val (reg_val),
        .rd_idx (reg_rd_sel),
        .rd_val (reg_rd_val),
        .step   (step)
    );

    vidctl_addr_unit #(.ADDR_W(ADDR_W), .LOW_W(LOW_W), .STEP_W(REG_W)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctrl_wr   (ctrl_wr),
        .ctrl_rd   (ctrl_rd),
        .ctrl_word (host_wdata),
        .reg_form  (reg_form),
        .data_adv  (data_go),
        .step      (step),
        .reg_wr_en (reg_wr_en),
        .ptr       (ptr),
        .tgt       (tgt),
        .pending   (pending)
    );

    // Registered write strobes, addresses and data toward the memories.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vram_we    <= 1'b0;
            cram_we    <= 1'b0;
            vram_waddr <= '0;
            cram_waddr <= '0;
            mem_wdata  <= '0;
        end else begin
            vram_we <= data_go && (tgt == TGT_VRAM);
            cram_we <= data_go && (tgt == TGT_CRAM);
            if (data_go) begin
                vram_waddr <= ptr[ADDR_W-1:1];
                cram_waddr <= ptr[CRAM_IDX_W:1];
                mem_wdata  <= host_wdata;
            end
        end
    end

    assert_vram_strobe_origin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        vram_we |-> ($past(data_wr) && !$past(ctrl_wr)));

    assert_collision_drops_data_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && data_wr) |=> (!vram_we && !cram_we));

    assert_single_strobe_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !(vram_we && cram_we));
endmodule

// File: tb/tb_vidctl_host_port.sv
`timescale 1ns/1ps
module tb_vidctl_host_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_wr = 1'b0;
    logic        ctrl_rd = 1'b0;
    logic        data_wr = 1'b0;
    logic [15:0] host_wdata = '0;
    logic [4:0]  reg_rd_sel = '0;
    logic [7:0]  reg_rd_val;
    logic        vram_we;
    logic [14:0] vram_waddr;
    logic        cram_we;
    logic [5:0]  cram_waddr;
    logic [15:0] mem_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench-side model of the programmer-visible state, built from the requirements.
    logic [15:0] m_ptr = '0;
    logic [1:0]  m_code = '0;
    bit          m_pend = 1'b0;
    logic [7:0]  m_regs [24];

    always #10 clk = ~clk;

    vidctl_host_port dut (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_rd(ctrl_rd),
        .data_wr(data_wr), .host_wdata(host_wdata), .reg_rd_sel(reg_rd_sel),
        .reg_rd_val(reg_rd_val), .vram_we(vram_we), .vram_waddr(vram_waddr),
        .cram_we(cram_we), .cram_waddr(cram_waddr), .mem_wdata(mem_wdata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic ctrl_write(input logic [15:0] w);
        @(negedge clk);
        ctrl_wr = 1'b1; host_wdata = w;
        @(negedge clk);
        ctrl_wr = 1'b0;
        if (m_pend) begin
            m_ptr[15:14] = w[1:0]; m_pend = 1'b0;
        end else if (w[15:13] == 3'b100) begin
            if (w[12:8] < 5'd24) m_regs[w[12:8]] = w[7:0];
        end else begin
            m_code = w[15:14]; m_ptr[13:0] = w[13:0]; m_pend = 1'b1;
        end
    endtask

    task automatic addr_cmd(input logic [1:0] code, input logic [15:0] a);
        ctrl_write({code, a[13:0]});
        ctrl_write({14'd0, a[15:14]});
    endtask

    // Compare strobe outputs against the model and advance the model pointer.
    task automatic expect_strobe(input string req, input logic [15:0] w);
        chk({req, " vram_we"}, {31'd0, vram_we}, {31'd0, m_code == 2'b01});
        chk({req, " cram_we"}, {31'd0, cram_we}, {31'd0, m_code == 2'b11});
        if (m_code == 2'b01) chk({req, " vram_waddr"}, {17'd0, vram_waddr}, {17'd0, m_ptr[15:1]});
        if (m_code == 2'b11) chk({req, " cram_waddr"}, {26'd0, cram_waddr}, {26'd0, m_ptr[6:1]});
        if (m_code[0]) chk({req, " mem_wdata"}, {16'd0, mem_wdata}, {16'd0, w});
        m_ptr = m_ptr + {8'd0, m_regs[15]};
    endtask

    task automatic data_write(input string req, input logic [15:0] w);
        @(negedge clk);
        data_wr = 1'b1; host_wdata = w;
        @(negedge clk);
        data_wr = 1'b0;
        expect_strobe(req, w);
    endtask

    task automatic check_regs(input string req);
        for (int i = 0; i < 32; i++) begin
            reg_rd_sel = 5'(i);
            #1;
            chk(req, {24'd0, reg_rd_val}, (i < 24) ? {24'd0, m_regs[i]} : 32'd0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 24; i++) m_regs[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state, and no strobe before any address command
        chk("R1 vram_we", {31'd0, vram_we}, 32'd0);
        chk("R1 cram_we", {31'd0, cram_we}, 32'd0);
        check_regs("R1 reg reset");
        data_write("R1 no target", 16'hABCD);

        // R2, R3: sweep every index 0..31; 24..31 must not land
        for (int i = 0; i < 32; i++) ctrl_write({3'b100, 5'(i), 8'((i * 7 + 3) & 8'hFF)});
        check_regs("R2 R3 reg sweep");

        // R4, R5, R8: VRAM write run with step 2
        ctrl_write(16'h8F02);
        addr_cmd(2'b01, 16'hC108);
        for (int k = 0; k < 11; k++) data_write("R5 R8 vram run", 16'(16'h0100 + k));

        // R8: step sweep
        foreach (m_regs[j]) if (j == 0) ;
        for (int s = 0; s < 6; s++) begin
            logic [7:0] st;
            st = (s == 0) ? 8'h00 : (s == 1) ? 8'h01 : (s == 2) ? 8'h03 :
                 (s == 3) ? 8'h40 : (s == 4) ? 8'hFF : 8'h80;
            ctrl_write({8'h8F, st});
            addr_cmd(2'b01, 16'h4000 + 16'(s * 16'h0111));
            for (int k = 0; k < 4; k++) data_write("R8 step sweep", 16'(s * 16 + k));
        end

        // R8: wrap past the top of the address space
        ctrl_write(16'h8F02);
        addr_cmd(2'b01, 16'hFFFE);
        for (int k = 0; k < 3; k++) data_write("R8 wrap", 16'(16'hE000 + k));

        // R6: every colour entry, then wrap of the index, then high bits ignored
        addr_cmd(2'b11, 16'h0000);
        for (int k = 0; k < 65; k++) data_write("R6 cram sweep", 16'(k * 16'h0111));
        addr_cmd(2'b11, 16'hC186);
        data_write("R6 high bits ignored", 16'h0E0E);

        // R4: second word completes the command even when it looks like a register write
        ctrl_write(16'h4020);
        ctrl_write(16'h8001);
        check_regs("R4 second word no reg write");
        data_write("R4 address from two words", 16'h1111);

        // R9: control read abandons a half command
        ctrl_write(16'h4040);
        @(negedge clk); ctrl_rd = 1'b1;
        @(negedge clk); ctrl_rd = 1'b0; m_pend = 1'b0;
        ctrl_write(16'h8F04);
        check_regs("R9 reg write after read");
        data_write("R9 pointer kept", 16'h2222);
        data_write("R9 step 4", 16'h3333);

        // R7: codes 00 and 10 issue no strobes
        addr_cmd(2'b00, 16'h0010);
        data_write("R7 code 00", 16'h4444);
        addr_cmd(2'b10, 16'h2010);
        data_write("R7 code 10", 16'h5555);

        // R10: two data writes on consecutive cycles (32-bit store, high half first)
        ctrl_write(16'h8F02);
        addr_cmd(2'b01, 16'h0200);
        @(negedge clk); data_wr = 1'b1; host_wdata = 16'h1234;
        @(negedge clk); host_wdata = 16'h5678;
        expect_strobe("R10 high half", 16'h1234);
        @(negedge clk); data_wr = 1'b0;
        expect_strobe("R10 low half", 16'h5678);

        // R11: control and data in the same cycle; data dropped, no advance
        @(negedge clk); ctrl_wr = 1'b1; data_wr = 1'b1; host_wdata = 16'h8701;
        @(negedge clk); ctrl_wr = 1'b0; data_wr = 1'b0;
        m_regs[7] = 8'h01;
        chk("R11 no vram strobe", {31'd0, vram_we}, 32'd0);
        chk("R11 no cram strobe", {31'd0, cram_we}, 32'd0);
        check_regs("R11 control applied");
        data_write("R11 pointer not advanced", 16'h6666);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule